// File: doc/BRIEF.md
# Twin-Predicated Vector Element Sequencer

This block walks the element positions of one vector operation and hands out, one per cycle, a pair made of a source element index and a destination element index. Each pair stands for one scalar operation that the surrounding datapath performs. The source side and the destination side each have their own predicate mask, taken from an integer register and optionally complemented. Each side independently skips its disabled elements, so a source element can feed a destination element at a different position.

A one-cycle start pulse loads the vector length, both masks, both invert flags and both starting step values. A nonzero starting step lets an interrupted loop carry on where it stopped: positions below the step are never revisited. The current step of each side is visible on the ports so that it can be saved if the loop is interrupted. When either side has no enabled element left below the vector length, a one-cycle done pulse ends the loop and both steps return to zero.

Top module: `elem_pair_seq`

## Requirements
- R1: While and right after reset, `busy_o`, `pair_valid_o` and `done_o` are low and both step outputs are zero.
- R2: Bit i of a side's effective mask enables element i of that side; an invert flag of 1 makes the effective mask the bitwise complement of the loaded mask. Every issued index points at a set bit of its side's effective mask.
- R3: The k-th pair of a loop carries the k-th enabled source position at or above the source start and the k-th enabled destination position at or above the destination start, so the two indices may differ.
- R4: The first pair appears on the outputs in the cycle after the start cycle, and further pairs follow in back-to-back cycles with strictly increasing indices on each side.
- R5: The loop ends when either side has no enabled element left below the vector length; `done_o` is then high for exactly one cycle, in the cycle after the last pair (or after the start cycle if there is no pair), and `busy_o` falls in that same cycle. `done_o` and `pair_valid_o` are never high together.
- R6: If either effective mask has no set bit within the vector length, no pair is issued and `done_o` rises in the cycle after start.
- R7: Mask bits below each starting step are ignored. Example: length 4, source mask 0b0101 from step 1, destination mask 0b0101 inverted from step 2, yields exactly one pair, source 2 to destination 3.
- R8: If a starting step is at or beyond the vector length (including length 0), no pair is issued and `done_o` rises in the cycle after start.
- R9: In a cycle that shows a pair, each step output equals that side's index plus one; when `done_o` is high both step outputs are zero.
- R10: A requested length above VL_MAX is treated as VL_MAX, and mask bits at or above the effective length never enable an element.
- R11: A start pulse while a loop is busy abandons that loop without a done pulse: the start cycle shows neither pair nor done, and the new loop proceeds as in R4.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | One-cycle load pulse for a new loop |
| vl_i | input | IDX_W | Requested vector length |
| src_mask_i | input | VL_MAX | Source predicate register value |
| dst_mask_i | input | VL_MAX | Destination predicate register value |
| src_inv_i | input | 1 | Use the source mask complemented |
| dst_inv_i | input | 1 | Use the destination mask complemented |
| src_start_i | input | IDX_W | Starting source step |
| dst_start_i | input | IDX_W | Starting destination step |
| pair_valid_o | output | 1 | A pair is presented this cycle |
| src_idx_o | output | IDX_W | Source element index of the pair |
| dst_idx_o | output | IDX_W | Destination element index of the pair |
| done_o | output | 1 | One-cycle end-of-loop pulse |
| busy_o | output | 1 | A loop is in progress |
| src_step_o | output | IDX_W | Current source step, for saving on interrupt |
| dst_step_o | output | IDX_W | Current destination step, for saving on interrupt |

## Verification
The bench builds the block with VL_MAX of 16, so IDX_W is 5 and the length input can request up to 31. That keeps full-width masks small enough for random values to hit sparse, dense, empty and full patterns often, while lengths above 16 exercise the clamp of R10 and starts beyond the length exercise R8. Every issued pair, every step value and the timing of the done pulse are compared cycle by cycle against a bench model of the stepping rule.

// File: rtl/pseq_pkg.sv
package pseq_pkg;

  typedef enum logic {
    SEQ_IDLE = 1'b0,
    SEQ_RUN  = 1'b1
  } seq_state_e;

endpackage

// File: rtl/pseq_mask_load.sv
module pseq_mask_load #(
  parameter int W = 64
) (
  input  logic [W-1:0] raw_i,
  input  logic         inv_i,
  output logic [W-1:0] eff_o
);

  always_comb begin
    eff_o = inv_i ? ~raw_i : raw_i;
  end

endmodule

// File: rtl/pseq_first_set.sv
module pseq_first_set #(
  parameter int W  = 64,
  parameter int IW = 7
) (
  input  logic [W-1:0]  vec_i,
  output logic          hit_o,
  output logic [IW-1:0] idx_o
);

  // lowest set bit wins
  always_comb begin
    hit_o = 1'b0;
    idx_o = '0;
    for (int i = W - 1; i >= 0; i--) begin
      if (vec_i[i]) begin
        hit_o = 1'b1;
        idx_o = IW'(i);
      end
    end
  end

endmodule

// File: rtl/pseq_lane.sv
module pseq_lane #(
  parameter int W  = 64,
  parameter int IW = 7
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load_i,
  input  logic [W-1:0]  mask_i,
  input  logic          inv_i,
  input  logic [IW-1:0] step_i,
  input  logic [IW-1:0] vl_i,
  input  logic          adv_i,
  input  logic          clr_i,
  output logic          hit_o,
  output logic [IW-1:0] next_o,
  output logic [IW-1:0] step_o,
  output logic [W-1:0]  mask_o
);

  logic [W-1:0]  eff_mask;
  logic [W-1:0]  mask_q;
  logic [IW-1:0] step_q;
  logic [W-1:0]  window;

  pseq_mask_load #(.W(W)) u_load (
    .raw_i (mask_i),
    .inv_i (inv_i),
    .eff_o (eff_mask)
  );

  // qualify each bit by the current step and the loop length
  for (genvar gi = 0; gi < W; gi++) begin : g_win
    assign window[gi] = mask_q[gi] && (IW'(gi) >= step_q) && (IW'(gi) < vl_i);
  end

  pseq_first_set #(.W(W), .IW(IW)) u_find (
    .vec_i (window),
    .hit_o (hit_o),
    .idx_o (next_o)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      mask_q <= '0;
      step_q <= '0;
    end else if (load_i) begin
      mask_q <= eff_mask;
      step_q <= step_i;
    end else if (adv_i) begin
      step_q <= next_o + IW'(1);
    end else if (clr_i) begin
      step_q <= '0;
    end
  end

  assign step_o = step_q;
  assign mask_o = mask_q;

endmodule

// File: rtl/elem_pair_seq.sv
module elem_pair_seq
  import pseq_pkg::*;
#(
  parameter int VL_MAX = 64,
  parameter int IDX_W  = $clog2(VL_MAX + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start_i,
  input  logic [IDX_W-1:0]  vl_i,
  input  logic [VL_MAX-1:0] src_mask_i,
  input  logic [VL_MAX-1:0] dst_mask_i,
  input  logic              src_inv_i,
  input  logic              dst_inv_i,
  input  logic [IDX_W-1:0]  src_start_i,
  input  logic [IDX_W-1:0]  dst_start_i,
  output logic              pair_valid_o,
  output logic [IDX_W-1:0]  src_idx_o,
  output logic [IDX_W-1:0]  dst_idx_o,
  output logic              done_o,
  output logic              busy_o,
  output logic [IDX_W-1:0]  src_step_o,
  output logic [IDX_W-1:0]  dst_step_o
);

  localparam logic [IDX_W-1:0] VL_CAP = IDX_W'(VL_MAX);

  seq_state_e        state_q;
  logic [IDX_W-1:0]  vl_q;
  logic [IDX_W-1:0]  vl_clamped;
  logic              src_hit, dst_hit, both_hit;
  logic [IDX_W-1:0]  src_next, dst_next;
  logic [VL_MAX-1:0] src_mask, dst_mask;
  logic              running, issue, finish;

  assign vl_clamped = (vl_i > VL_CAP) ? VL_CAP : vl_i;
  assign running    = (state_q == SEQ_RUN) && !start_i;
  assign both_hit   = src_hit && dst_hit;
  assign issue      = running && both_hit;
  assign finish     = running && !both_hit;

  pseq_lane #(.W(VL_MAX), .IW(IDX_W)) u_src (
    .clk    (clk),
    .rst    (rst),
    .load_i (start_i),
    .mask_i (src_mask_i),
    .inv_i  (src_inv_i),
    .step_i (src_start_i),
    .vl_i   (vl_q),
    .adv_i  (issue),
    .clr_i  (finish),
    .hit_o  (src_hit),
    .next_o (src_next),
    .step_o (src_step_o),
    .mask_o (src_mask)
  );

  pseq_lane #(.W(VL_MAX), .IW(IDX_W)) u_dst (
    .clk    (clk),
    .rst    (rst),
    .load_i (start_i),
    .mask_i (dst_mask_i),
    .inv_i  (dst_inv_i),
    .step_i (dst_start_i),
    .vl_i   (vl_q),
    .adv_i  (issue),
    .clr_i  (finish),
    .hit_o  (dst_hit),
    .next_o (dst_next),
    .step_o (dst_step_o),
    .mask_o (dst_mask)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q      <= SEQ_IDLE;
      vl_q         <= '0;
      pair_valid_o <= 1'b0;
      done_o       <= 1'b0;
      src_idx_o    <= '0;
      dst_idx_o    <= '0;
    end else begin
      pair_valid_o <= 1'b0;
      done_o       <= 1'b0;
      if (start_i) begin
        state_q <= SEQ_RUN;
        vl_q    <= vl_clamped;
      end else if (issue) begin
        pair_valid_o <= 1'b1;
        src_idx_o    <= src_next;
        dst_idx_o    <= dst_next;
      end else if (finish) begin
        done_o  <= 1'b1;
        state_q <= SEQ_IDLE;
      end
    end
  end

  assign busy_o = (state_q == SEQ_RUN);

endmodule

// File: rtl/elem_pair_seq_chk.sv
module elem_pair_seq_chk #(
  parameter int VL_MAX = 64,
  parameter int IDX_W  = 7
) (
  input logic              clk,
  input logic              rst,
  input logic              start_i,
  input logic              pair_valid_o,
  input logic              done_o,
  input logic              busy_o,
  input logic [IDX_W-1:0]  src_idx_o,
  input logic [IDX_W-1:0]  dst_idx_o,
  input logic [IDX_W-1:0]  src_step_o,
  input logic [IDX_W-1:0]  dst_step_o,
  input logic [IDX_W-1:0]  vl_q,
  input logic [VL_MAX-1:0] src_mask,
  input logic [VL_MAX-1:0] dst_mask
);

  assert_pair_on_set_bits_R2: assert property (@(posedge clk) disable iff (rst)
    pair_valid_o |-> ((src_mask >> src_idx_o) & VL_MAX'(1)) != '0
                  && ((dst_mask >> dst_idx_o) & VL_MAX'(1)) != '0);

  assert_indices_rise_R4: assert property (@(posedge clk) disable iff (rst)
    (pair_valid_o && $past(pair_valid_o)) |->
      (src_idx_o > $past(src_idx_o)) && (dst_idx_o > $past(dst_idx_o)));

  assert_done_excl_R5: assert property (@(posedge clk) disable iff (rst)
    done_o |-> !pair_valid_o && !busy_o);

  assert_step_follows_R9: assert property (@(posedge clk) disable iff (rst)
    pair_valid_o |-> (src_step_o == src_idx_o + IDX_W'(1))
                  && (dst_step_o == dst_idx_o + IDX_W'(1)));

  assert_steps_cleared_R9: assert property (@(posedge clk) disable iff (rst)
    done_o |-> (src_step_o == '0) && (dst_step_o == '0));

  assert_within_length_R10: assert property (@(posedge clk) disable iff (rst)
    pair_valid_o |-> (src_idx_o < vl_q) && (dst_idx_o < vl_q)
                  && (vl_q <= IDX_W'(VL_MAX)));

  assert_restart_quiet_R11: assert property (@(posedge clk) disable iff (rst)
    start_i |=> !pair_valid_o && !done_o && busy_o);

endmodule

bind elem_pair_seq elem_pair_seq_chk #(.VL_MAX(VL_MAX), .IDX_W(IDX_W)) u_chk (
  .clk          (clk),
  .rst          (rst),
  .start_i      (start_i),
  .pair_valid_o (pair_valid_o),
  .done_o       (done_o),
  .busy_o       (busy_o),
  .src_idx_o    (src_idx_o),
  .dst_idx_o    (dst_idx_o),
  .src_step_o   (src_step_o),
  .dst_step_o   (dst_step_o),
  .vl_q         (vl_q),
  .src_mask     (src_mask),
  .dst_mask     (dst_mask)
);

// File: tb/sim_elem_pair_seq.sv
module sim_elem_pair_seq;

  localparam int VL_MAX = 16;
  localparam int IDX_W  = $clog2(VL_MAX + 1);

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              start_i = 1'b0;
  logic [IDX_W-1:0]  vl_i = '0;
  logic [VL_MAX-1:0] src_mask_i = '0;
  logic [VL_MAX-1:0] dst_mask_i = '0;
  logic              src_inv_i = 1'b0;
  logic              dst_inv_i = 1'b0;
  logic [IDX_W-1:0]  src_start_i = '0;
  logic [IDX_W-1:0]  dst_start_i = '0;
  logic              pair_valid_o, done_o, busy_o;
  logic [IDX_W-1:0]  src_idx_o, dst_idx_o, src_step_o, dst_step_o;

  int n_checks = 0;
  int n_errors = 0;
  int exp_n;
  int exp_s[VL_MAX+1];
  int exp_d[VL_MAX+1];

  always #10 clk = ~clk;

  elem_pair_seq #(.VL_MAX(VL_MAX), .IDX_W(IDX_W)) u0 (
    .clk(clk), .rst(rst), .start_i(start_i), .vl_i(vl_i),
    .src_mask_i(src_mask_i), .dst_mask_i(dst_mask_i),
    .src_inv_i(src_inv_i), .dst_inv_i(dst_inv_i),
    .src_start_i(src_start_i), .dst_start_i(dst_start_i),
    .pair_valid_o(pair_valid_o), .src_idx_o(src_idx_o), .dst_idx_o(dst_idx_o),
    .done_o(done_o), .busy_o(busy_o),
    .src_step_o(src_step_o), .dst_step_o(dst_step_o)
  );

  task automatic chk(string req, int act, int exp);
    n_checks++;
    if (act != exp) begin
      n_errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // bench model of the stepping rule
  task automatic build_expect(int vl, logic [VL_MAX-1:0] sm, logic [VL_MAX-1:0] dm,
                              bit si, bit di, int ss, int ds);
    logic [VL_MAX-1:0] es, ed;
    int s, d, lim;
    es = si ? ~sm : sm;
    ed = di ? ~dm : dm;
    lim = (vl > VL_MAX) ? VL_MAX : vl;
    s = ss; d = ds; exp_n = 0;
    forever begin
      while (s < lim && !es[s]) s++;
      while (d < lim && !ed[d]) d++;
      if (s >= lim || d >= lim) break;
      exp_s[exp_n] = s; exp_d[exp_n] = d; exp_n++;
      s++; d++;
    end
  endtask

  task automatic drive(int vl, logic [VL_MAX-1:0] sm, logic [VL_MAX-1:0] dm,
                       bit si, bit di, int ss, int ds);
    vl_i = IDX_W'(vl); src_mask_i = sm; dst_mask_i = dm;
    src_inv_i = si; dst_inv_i = di;
    src_start_i = IDX_W'(ss); dst_start_i = IDX_W'(ds);
    start_i = 1'b1;
  endtask

  // called at the falling edge right after the loading edge
  task automatic follow(string tag);
    for (int j = 0; j < exp_n; j++) begin
      @(negedge clk);
      chk("R4 pair valid", int'(pair_valid_o), 1);
      chk("R3 source index", int'(src_idx_o), exp_s[j]);
      chk("R3 destination index", int'(dst_idx_o), exp_d[j]);
      chk("R9 source step", int'(src_step_o), exp_s[j] + 1);
      chk("R9 destination step", int'(dst_step_o), exp_d[j] + 1);
      chk("R5 no done during pairs", int'(done_o), 0);
    end
    @(negedge clk);
    chk(tag, int'(done_o), 1);
    chk("R5 no pair with done", int'(pair_valid_o), 0);
    chk("R5 busy low at done", int'(busy_o), 0);
    chk("R9 steps cleared", int'(src_step_o) + int'(dst_step_o), 0);
    @(negedge clk);
    chk("R5 done lasts one cycle", int'(done_o), 0);
  endtask

  task automatic run_case(int vl, logic [VL_MAX-1:0] sm, logic [VL_MAX-1:0] dm,
                          bit si, bit di, int ss, int ds, string tag);
    build_expect(vl, sm, dm, si, di, ss, ds);
    @(negedge clk);
    drive(vl, sm, dm, si, di, ss, ds);
    @(negedge clk);
    start_i = 1'b0;
    chk("R4 nothing on start cycle", int'(pair_valid_o) + int'(done_o), 0);
    follow(tag);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_errors++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk);
    chk("R1 busy in reset", int'(busy_o), 0);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 pair valid", int'(pair_valid_o), 0);
    chk("R1 done", int'(done_o), 0);
    chk("R1 steps", int'(src_step_o) + int'(dst_step_o), 0);
    chk("R1 busy", int'(busy_o), 0);

    // R7 resume example: single pair 2 -> 3
    build_expect(4, 16'h0005, 16'h0005, 1'b0, 1'b1, 1, 2);
    chk("R7 model pair count", exp_n, 1);
    run_case(4, 16'h0005, 16'h0005, 1'b0, 1'b1, 1, 2, "R7 resume done");
    // R7 bits below start set but ignored
    run_case(8, 16'h00ff, 16'h00ff, 1'b0, 1'b0, 5, 3, "R7 below-start ignored");
    // R6 empty masks
    run_case(3, 16'h0000, 16'h0000, 1'b0, 1'b0, 0, 0, "R6 all zero done");
    run_case(6, 16'h0000, 16'h0000, 1'b0, 1'b1, 0, 0, "R6 source empty done");
    // R2 inverted empty mask selects everything
    run_case(8, 16'h0000, 16'h00f0, 1'b1, 1'b0, 0, 0, "R2 invert flag done");
    run_case(8, 16'h0035, 16'h00ca, 1'b1, 1'b1, 0, 0, "R2 both inverted done");
    // R3 independent advance
    run_case(12, 16'h0011, 16'h0300, 1'b0, 1'b0, 0, 0, "R3 independent done");
    // R8 start at or past the length
    run_case(5, 16'hffff, 16'hffff, 1'b0, 1'b0, 5, 0, "R8 start at length");
    run_case(5, 16'hffff, 16'hffff, 1'b0, 1'b0, 0, 9, "R8 start past length");
    run_case(0, 16'hffff, 16'hffff, 1'b0, 1'b0, 0, 0, "R8 zero length");
    // R10 clamp and bits above length
    run_case(25, 16'hffff, 16'hffff, 1'b0, 1'b0, 0, 0, "R10 clamped length");
    run_case(4, 16'hfff0, 16'hffff, 1'b0, 1'b0, 0, 0, "R10 bits above length");
    run_case(4, 16'hfff3, 16'hfff9, 1'b0, 1'b0, 0, 0, "R10 partial above length");

    // R11 restart while busy
    @(negedge clk);
    drive(8, 16'h00ff, 16'h00ff, 1'b0, 1'b0, 0, 0);
    @(negedge clk);
    start_i = 1'b0;
    @(negedge clk);
    chk("R11 first loop issued", int'(pair_valid_o), 1);
    build_expect(6, 16'h0024, 16'h0030, 1'b0, 1'b0, 1, 0);
    drive(6, 16'h0024, 16'h0030, 1'b0, 1'b0, 1, 0);
    @(negedge clk);
    start_i = 1'b0;
    chk("R11 restart cycle quiet", int'(pair_valid_o) + int'(done_o), 0);
    chk("R11 still busy", int'(busy_o), 1);
    follow("R11 new loop done");

    // R3 constrained random
    for (int k = 0; k < 200; k++) begin
      int vl, ss, ds;
      logic [VL_MAX-1:0] sm, dm;
      vl = int'($urandom_range(0, 20));
      ss = ($urandom_range(0, 3) == 0) ? int'($urandom_range(0, 18)) : 0;
      ds = ($urandom_range(0, 3) == 0) ? int'($urandom_range(0, 18)) : 0;
      sm = VL_MAX'($urandom);
      dm = VL_MAX'($urandom);
      if ($urandom_range(0, 4) == 0) sm = sm & VL_MAX'($urandom);
      run_case(vl, sm, dm, 1'($urandom), 1'($urandom), ss, ds, "R3 random done");
    end

    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  end

endmodule